// File: doc/BRIEF.md
# TDM Serial Port with Frame-Pulse Format Sensing

This block is the serial front end for one time-division-multiplexed stream pair running off a single master clock. On the receive side it turns the incoming serial bit stream into channel bytes, each tagged with its channel index. On the transmit side it asks for one byte per channel and shifts that byte out. Two bit-rate families are supported. In the fast setting each master clock period carries one bit (256 channels per frame). In the three slower settings each bit lasts two master clocks (32, 64 or 128 channels per frame).

No configuration bit selects the framing convention. The block watches the frame pulse and works out which convention is in use. A pulse that idles high and dips low is treated as the falling-edge-launch convention (called "low-pulse format" below). A pulse that idles low and rises is treated as the rising-edge-launch convention ("high-pulse format"). The detector is a three-state machine. In HUNT it waits for a first pulse; the transition FIRST leads to ONE. In ONE it waits for a second pulse of the same polarity: the transition CONFIRM leads to HOLD, while REPOL stays in ONE and records the new polarity. In HOLD each matching pulse is a frame start (FRAME); a pulse of the other polarity is LOSS and returns the machine to ONE. The format decides the launch edge, the sample edge and the bit order on the wire.

Top module: `tdm_serial_port`

## Requirements
- R1: After reset, fmt_locked and rx_valid are 0, dout is 1 and tx_chan is 0.
- R2: A level change on fp_in after at least 8 rising-edge samples of a steady level counts as a frame pulse. A high-to-low change means low-pulse format (fmt_gci = 0). A low-to-high change means high-pulse format (fmt_gci = 1).
- R3: A single pulse does not set fmt_locked. fmt_locked rises at the second consecutive pulse of the same polarity, and the polarity does not change in that cycle. A pulse of the opposite polarity clears fmt_locked. Edge 0 of a frame is the rising clock edge at which a matching pulse is first sampled.
- R4: With rate_sel = 3 (one clock per bit), bit n of a frame is sampled at rising edge n+1 in low-pulse format. In high-pulse format it is sampled at the falling edge just before rising edge n+1. With rate_sel 0 to 2 (two clocks per bit), bit n is sampled at rising edge 2n+2 in low-pulse format. In high-pulse format it is sampled at the falling edge just before rising edge 2n+2. Both points lie three quarters of the way through the bit.
- R5: In low-pulse format bytes travel most significant bit first. In high-pulse format they travel least significant bit first. This holds for both directions.
- R6: rx_valid is a one-cycle pulse, driven in the cycle after the edge that samples a channel's last bit, together with rx_byte and rx_chan. Channels of a frame are numbered from 0 in arrival order.
- R7: There are 32, 64, 128 or 256 channels per frame for rate_sel 0, 1, 2 or 3. rx_chan wraps to 0 after the last channel, and a frame start forces it to 0.
- R8: Let k be 1 or 2 clocks per bit. Transmit bit n is launched at rising edge n·k in high-pulse format. In low-pulse format it is launched at the falling edge after rising edge n·k. tx_data is taken for channel tx_chan at the rising edge where bit 0 of that channel launches, and tx_chan then steps, wrapping with the channel count.
- R9: While fmt_locked is 0, dout stays at 1.
- R10: While fmt_locked is 0, rx_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Rate: 0..2 two clocks per bit (32/64/128 ch), 3 one clock per bit (256 ch) |
| fp_in | input | 1 | Frame pulse, either polarity |
| din | input | 1 | Serial receive data |
| dout | output | 1 | Serial transmit data |
| fmt_locked | output | 1 | Format confirmed by two matching pulses |
| fmt_gci | output | 1 | 1 = high-pulse format, 0 = low-pulse format |
| rx_valid | output | 1 | Received byte strobe |
| rx_byte | output | 8 | Received channel byte |
| rx_chan | output | CHW (8) | Channel index of rx_byte |
| tx_chan | output | CHW (8) | Channel whose byte is taken next from tx_data |
| tx_data | input | 8 | Transmit byte for channel tx_chan |

## Verification
If the detector is in the wrong state, fmt_locked or fmt_gci shows it on the clock after the offending pulse edge. The wrong edge choice then shows as bytes that are shifted or bit-reversed at the first rx_valid of the locked frame, 8 or 16 clocks after edge 0. A slip in the bit or channel counters shows within one frame. rx_chan misses the expected index, and the received byte count per frame differs from the channel count for the selected rate. Transmit slips show on dout at the first bit cell checked after edge 0.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    typedef enum logic [1:0] {
        LK_HUNT = 2'd0,
        LK_ONE  = 2'd1,
        LK_HOLD = 2'd2
    } lock_st_t;

    localparam int BASE_CH = 32;
endpackage

// File: rtl/tdm_fmt_detect.sv
module tdm_fmt_detect
    import tdm_pkg::*;
#(
    parameter int IDLE_MIN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fp,
    output logic frame_start,
    output logic locked,
    output logic gci
);
    localparam int RW = $clog2(IDLE_MIN + 1);

    lock_st_t       st_q, st_d;
    logic           pol_q, pol_d;
    logic           fp_s;
    logic [RW-1:0]  run_q;
    logic           edge_seen, cand, cand_gci, match;

    assign edge_seen = (fp != fp_s);
    assign cand      = edge_seen && (run_q == RW'(IDLE_MIN));
    assign cand_gci  = ~fp_s;
    assign match     = cand && (cand_gci == pol_q);

    // level history of the frame pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fp_s  <= 1'b1;
            run_q <= '0;
        end else begin
            fp_s <= fp;
            if (edge_seen)
                run_q <= '0;
            else if (run_q != RW'(IDLE_MIN))
                run_q <= run_q + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= LK_HUNT;
            pol_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            pol_q <= pol_d;
        end
    end

    // transitions: FIRST, CONFIRM, REPOL, FRAME, LOSS
    always_comb begin
        st_d  = st_q;
        pol_d = pol_q;
        unique case (st_q)
            LK_HUNT: if (cand) begin
                st_d  = LK_ONE;
                pol_d = cand_gci;
            end
            LK_ONE: begin
                if (match)
                    st_d = LK_HOLD;
                else if (cand)
                    pol_d = cand_gci;
            end
            LK_HOLD: if (cand && !match) begin
                st_d  = LK_ONE;
                pol_d = cand_gci;
            end
            default: st_d = LK_HUNT;
        endcase
    end

    // outputs
    always_comb begin
        locked      = (st_q == LK_HOLD);
        gci         = pol_q;
        frame_start = match && (st_q != LK_HUNT);
    end
endmodule

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic locked,
    input  logic one_clk,
    output logic stb
);
    logic run_q, ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            ph_q  <= 1'b0;
        end else begin
            if (frame_start)
                run_q <= 1'b1;
            else if (!locked)
                run_q <= 1'b0;
            ph_q <= frame_start ? 1'b0 : ~ph_q;
        end
    end

    assign stb = run_q && locked && (one_clk || ph_q);
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
    parameter int CHW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stb,
    input  logic           frame_start,
    input  logic           gci,
    input  logic           bit_in,
    input  logic [CHW-1:0] nch_last,
    output logic           rx_valid,
    output logic [7:0]     rx_byte,
    output logic [CHW-1:0] rx_chan
);
    logic [6:0]     sh;
    logic [2:0]     bi;
    logic [CHW-1:0] ch;
    logic [7:0]     full;

    assign full = gci ? {bit_in, sh} : {sh, bit_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh       <= '0;
            bi       <= '0;
            ch       <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
            rx_chan  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (stb) begin
                sh <= gci ? full[7:1] : full[6:0];
                bi <= bi + 3'd1;
                if (bi == 3'd7) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= full;
                    rx_chan  <= ch;
                    ch       <= (ch == nch_last) ? '0 : ch + 1'b1;
                end
            end
            if (frame_start) begin
                bi <= '0;
                ch <= '0;
            end
        end
    end
endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser #(
    parameter int CHW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stb,
    input  logic           frame_start,
    input  logic           locked,
    input  logic           gci,
    input  logic [CHW-1:0] nch_last,
    input  logic [7:0]     tx_data,
    output logic           tx_bit,
    output logic [CHW-1:0] tx_chan
);
    logic [7:0] sh;
    logic [2:0] bi;
    logic       load;

    assign load = frame_start || (stb && bi == 3'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh      <= '0;
            bi      <= '0;
            tx_bit  <= 1'b1;
            tx_chan <= '0;
        end else if (!(locked || frame_start)) begin
            bi      <= '0;
            tx_bit  <= 1'b1;
            tx_chan <= '0;
        end else if (load) begin
            sh      <= tx_data;
            tx_bit  <= gci ? tx_data[0] : tx_data[7];
            bi      <= 3'd1;
            tx_chan <= (tx_chan == nch_last) ? '0 : tx_chan + 1'b1;
        end else if (stb) begin
            tx_bit <= gci ? sh[bi] : sh[3'd7 - bi];
            bi     <= bi + 3'd1;
        end
    end
endmodule

// File: rtl/tdm_serial_port.sv
module tdm_serial_port
    import tdm_pkg::*;
#(
    parameter int CHW      = 8,
    parameter int IDLE_MIN = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     rate_sel,
    input  logic           fp_in,
    input  logic           din,
    output logic           dout,
    output logic           fmt_locked,
    output logic           fmt_gci,
    output logic           rx_valid,
    output logic [7:0]     rx_byte,
    output logic [CHW-1:0] rx_chan,
    output logic [CHW-1:0] tx_chan,
    input  logic [7:0]     tx_data
);
    logic           fs, stb, one_clk;
    logic           rx_neg, rx_bit, tx_bit, tx_neg;
    logic [CHW-1:0] nch_last;

    assign one_clk  = (rate_sel == 2'd3);
    assign nch_last = CHW'((BASE_CH << rate_sel) - 1);

    tdm_fmt_detect #(.IDLE_MIN(IDLE_MIN)) u_det (
        .clk(clk), .rst_n(rst_n), .fp(fp_in),
        .frame_start(fs), .locked(fmt_locked), .gci(fmt_gci)
    );

    tdm_bit_timer u_tim (
        .clk(clk), .rst_n(rst_n), .frame_start(fs),
        .locked(fmt_locked), .one_clk(one_clk), .stb(stb)
    );

    // falling-edge capture and launch stages
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_neg <= 1'b0;
            tx_neg <= 1'b1;
        end else begin
            rx_neg <= din;
            tx_neg <= tx_bit;
        end
    end

    assign rx_bit = fmt_gci ? rx_neg : din;
    assign dout   = fmt_gci ? tx_bit : tx_neg;

    tdm_rx_deser #(.CHW(CHW)) u_rx (
        .clk(clk), .rst_n(rst_n), .stb(stb), .frame_start(fs),
        .gci(fmt_gci), .bit_in(rx_bit), .nch_last(nch_last),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_chan(rx_chan)
    );

    tdm_tx_ser #(.CHW(CHW)) u_tx (
        .clk(clk), .rst_n(rst_n), .stb(stb), .frame_start(fs),
        .locked(fmt_locked), .gci(fmt_gci), .nch_last(nch_last),
        .tx_data(tx_data), .tx_bit(tx_bit), .tx_chan(tx_chan)
    );
endmodule

// File: rtl/tdm_serial_port_chk.sv
module tdm_serial_port_chk #(
    parameter int CHW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [1:0]     rate_sel,
    input logic           dout,
    input logic           fmt_locked,
    input logic           fmt_gci,
    input logic           rx_valid,
    input logic [CHW-1:0] rx_chan
);
    AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(fmt_locked)); // R10

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R6

    AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (int'(rx_chan) < (32 << rate_sel))); // R7

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!fmt_locked && !$past(fmt_locked) && !$past(fmt_locked, 2)) |-> dout); // R9

    AST_LOCK_KEEPS_POL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fmt_locked) |-> $stable(fmt_gci)); // R3
endmodule

bind tdm_serial_port tdm_serial_port_chk #(.CHW(CHW)) u_chk (.*);

// File: tb/sim_tdm_serial_port.sv
`timescale 1ns/1ps
module sim_tdm_serial_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rate_sel = 2'd3;
    logic       fp_in = 1'b1;
    logic       din = 1'b0;
    logic       dout, fmt_locked, fmt_gci, rx_valid;
    logic [7:0] rx_byte, tx_data;
    logic [7:0] rx_chan, tx_chan;

    int n_tot = 0;
    int n_bad = 0;
    bit done = 0;

    int mon_on = 0, mon_quiet = 0, mon_f = 0, mon_c = 0, mon_n = 32, mon_cnt = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] rpat(input int f, input int c);
        return 8'((c * 29 + f * 71 + 3) & 255);
    endfunction

    function automatic logic [7:0] tpat(input int c);
        return 8'((c * 3) & 255) ^ 8'h5A;
    endfunction

    function automatic logic bitof(input logic [7:0] b, input int j, input bit g);
        return g ? b[j] : b[7-j];
    endfunction

    assign tx_data = tpat(int'(tx_chan));

    tdm_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .fp_in(fp_in), .din(din),
        .dout(dout), .fmt_locked(fmt_locked), .fmt_gci(fmt_gci),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_chan(rx_chan),
        .tx_chan(tx_chan), .tx_data(tx_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tot++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // receive monitor: R5, R6, R7, R10
    always @(posedge clk) begin
        #2;
        if (rx_valid) begin
            if (mon_quiet != 0)
                chk(0, "R10 rx_valid while unlocked", 1, 0);
            else if (mon_on != 0) begin
                chk(int'(rx_chan) == mon_c, "R6 rx_chan order", int'(rx_chan), mon_c);
                chk(rx_byte == rpat(mon_f, mon_c), "R5 R4 rx_byte",
                    int'(rx_byte), int'(rpat(mon_f, mon_c)));
                mon_cnt++;
                mon_c++;
                if (mon_c == mon_n) begin
                    mon_c = 0;
                    mon_f++;
                end
            end
        end
    end

    task automatic do_reset(input bit g, input logic [1:0] r);
        rst_n = 1'b0;
        fp_in = ~g;
        din = 1'b0;
        rate_sel = r;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // one frame; txmode 0: dout idle, 1: dout pattern
    task automatic run_frame(input bit g, input int f, input int txmode);
        int k, n, len, bn;
        k = (rate_sel == 2'd3) ? 1 : 2;
        n = 32 << rate_sel;
        len = n * 8 * k;
        fp_in = g;
        for (int t = 0; t < len; t++) begin
            @(posedge clk);
            #1;
            if (txmode == 1 && g && (t % k) == 0) begin
                bn = t / k;
                chk(dout == bitof(tpat(bn / 8), bn % 8, g), "R8 R5 dout high-pulse",
                    int'(dout), int'(bitof(tpat(bn / 8), bn % 8, g)));
            end
            if (txmode == 1 && !g && t >= 1 && ((t - 1) % k) == 0) begin
                bn = (t - 1) / k;
                chk(dout == bitof(tpat(bn / 8), bn % 8, g), "R8 R5 dout low-pulse",
                    int'(dout), int'(bitof(tpat(bn / 8), bn % 8, g)));
            end
            if (txmode == 0 && (t % 64) == 0)
                chk(dout == 1'b1, "R9 dout idle", int'(dout), 1);
            if (!g) @(negedge clk);
            if (t == k - 1) fp_in = ~g;
            if ((t % k) == 0) begin
                bn = t / k;
                din = bitof(rpat(f, bn / 8), bn % 8, g);
            end
        end
    endtask

    task automatic do_cfg(input bit g, input logic [1:0] r);
        int n;
        n = 32 << r;
        do_reset(g, r);
        repeat (20) @(posedge clk);
        if (g) begin
            @(posedge clk);
            #1;
        end else
            @(negedge clk);
        mon_quiet = 1;
        mon_on = 0;
        run_frame(g, 0, 0);
        chk(fmt_locked == 1'b0, "R3 one pulse no lock", int'(fmt_locked), 0);
        mon_quiet = 0;
        mon_f = 1;
        mon_c = 0;
        mon_n = n;
        mon_cnt = 0;
        mon_on = 1;
        run_frame(g, 1, 1);
        chk(fmt_locked == 1'b1, "R3 locked after two pulses", int'(fmt_locked), 1);
        chk(fmt_gci == g, "R2 format sensed", int'(fmt_gci), int'(g));
        run_frame(g, 2, 1);
        @(posedge clk);
        #3;
        mon_on = 0;
        chk(mon_cnt == 2 * n, "R7 channels per frame", mon_cnt, 2 * n);
    endtask

    task automatic t_reset;
        do_reset(1'b0, 2'd3);
        @(negedge clk);
        chk(fmt_locked == 1'b0, "R1 locked at reset", int'(fmt_locked), 0);
        chk(rx_valid == 1'b0, "R1 rx_valid at reset", int'(rx_valid), 0);
        chk(dout == 1'b1, "R1 dout at reset", int'(dout), 1);
        chk(tx_chan == 8'd0, "R1 tx_chan at reset", int'(tx_chan), 0);
    endtask

    // opposite pulse after lock in low-pulse format
    task automatic t_loss;
        @(posedge clk);
        #1 fp_in = 1'b0;
        repeat (12) @(posedge clk);
        #1;
        chk(fmt_locked == 1'b1, "R3 matching pulse keeps lock", int'(fmt_locked), 1);
        fp_in = 1'b1;
        @(posedge clk);
        #1;
        chk(fmt_locked == 1'b0, "R3 opposite pulse drops lock", int'(fmt_locked), 0);
        chk(fmt_gci == 1'b1, "R2 new polarity", int'(fmt_gci), 1);
    endtask

    initial begin
        t_reset();
        do_cfg(1'b0, 2'd3);
        t_loss();
        do_cfg(1'b1, 2'd0);
        do_cfg(1'b0, 2'd1);
        do_cfg(1'b1, 2'd2);
        do_cfg(1'b1, 2'd3);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            n_tot++;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end
endmodule